// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches the two independent ports of a shared true dual-port array, a left port and a right port. Each port presents a chip enable, a write strobe and a word address on every clock. When both ports are enabled and point at the same word, the arbiter picks the port that got there first and raises an active-low busy flag towards the other one. It also produces the write enable that each port may pass on to the array. The losing port cannot write, but it can still read, and its busy flag tells it that the data may not be settled.

A strap input selects one of two roles. In master role the arbiter makes the decision itself and drives its busy outputs. In slave role it makes no decision. Its busy outputs stay released, and it samples busy inputs that come from a master device. A port whose incoming busy is low then loses its write. Several devices can be joined in this way to widen the data word, with all of them following one arbitration result.

The winner is the port that was already in place. The other port is the later one, because it either moved its address onto the matching word or raised its chip enable while the addresses already matched. When both ports arrive in the same clock, a parameter picks the winner, and by default that is the left port. The grant is held in a registered owner state for as long as the match lasts.

Top module: `dp_contention_arbiter`

## Requirements
- R1: When the two chip enables are not both high, or when the two full word addresses differ, neither busy output goes low (busy is active low, 1 = released).
- R2: When a port changes its address onto the word that the other, already enabled and unchanged, port holds, that port's busy output goes low. It does so one clock after the inputs are sampled.
- R3: When a port raises its chip enable while its address already equals the other enabled port's address, that port's busy output goes low one clock later.
- R4: A busy output returns high one clock after the addresses stop matching, or one clock after either chip enable drops.
- R5: When both ports reach a match in the same clock, the tie parameter picks the winner (default: left wins, so right busy goes low). The two busy outputs are never low together.
- R6: While the match persists in every clock, the owner does not change, even if both ports move together to a new common address.
- R7: In master role (strap = 1), a port's array write enable is high only when its chip enable and write strobe are both high and it is not the losing port. It is registered with the same one-clock latency as busy.
- R8: In slave role (strap = 0), both busy outputs stay high. A port's array write enable is its chip enable AND its write strobe AND its sampled busy input (active low, 1 = allowed), delivered one clock later.
- R9: During reset both busy outputs are high and both array write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Role strap: 1 = master (decides and drives busy), 0 = slave (samples busy) |
| l_ce | input | 1 | Left port chip enable, active high |
| l_we | input | 1 | Left port write strobe, active high |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port chip enable, active high |
| r_we | input | 1 | Right port write strobe, active high |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | Busy from a master device for the left port, active low (slave role only) |
| r_busy_in_n | input | 1 | Busy from a master device for the right port, active low (slave role only) |
| l_busy_n | output | 1 | Busy to the left port, active low, registered |
| r_busy_n | output | 1 | Busy to the right port, active low, registered |
| l_arr_we | output | 1 | Gated left write enable towards the array, registered |
| r_arr_we | output | 1 | Gated right write enable towards the array, registered |

## Verification
Every result of this block is due exactly one clock after the edge that samples the inputs. That holds for the busy flags, the owner decision and both gated write enables, in either role. The bench applies each input vector at a falling edge and lets one rising edge register it. It then compares all four outputs at the following falling edge against a model that applies the requirements to the same vector and to the previous one. Arrival order depends on what each port held in the previous clock, so the model keeps the last applied vector. A tie is therefore only a tie when both ports changed in the same cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int SIDE_L = 0;
    localparam int SIDE_R = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dpa_match_detect.sv
module dpa_match_detect #(
    parameter int ADDR_W = 14
) (
    input  logic              l_ce,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              prev_l_ce,
    input  logic [ADDR_W-1:0] prev_l_addr,
    input  logic              prev_r_ce,
    input  logic [ADDR_W-1:0] prev_r_addr,
    output logic              match,
    output logic              l_moved,
    output logic              r_moved
);

    always_comb begin
        match   = l_ce && r_ce && (l_addr == r_addr);
        // a port "moved" if it was not enabled last clock or its address changed
        l_moved = !prev_l_ce || (l_addr != prev_l_addr);
        r_moved = !prev_r_ce || (r_addr != prev_r_addr);
    end

endmodule

// File: rtl/dpa_owner_next.sv
module dpa_owner_next
    import dpa_pkg::*;
#(
    parameter bit LEFT_WINS_TIE = 1'b1
) (
    input  logic   master_mode,
    input  logic   match,
    input  logic   l_moved,
    input  logic   r_moved,
    input  owner_e owner_q,
    output owner_e owner_d
);

    owner_e tie_owner;

    generate
        if (LEFT_WINS_TIE) begin : g_tie_left
            assign tie_owner = OWN_LEFT;
        end else begin : g_tie_right
            assign tie_owner = OWN_RIGHT;
        end
    endgenerate

    always_comb begin
        owner_d = OWN_NONE;
        if (master_mode && match) begin
            if (owner_q != OWN_NONE) begin
                owner_d = owner_q;
            end else if (l_moved && !r_moved) begin
                owner_d = OWN_RIGHT;
            end else if (r_moved && !l_moved) begin
                owner_d = OWN_LEFT;
            end else begin
                owner_d = tie_owner;
            end
        end
    end

endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate
    import dpa_pkg::*;
#(
    parameter int SIDE = 0
) (
    input  logic   master_mode,
    input  owner_e owner_d,
    input  logic   ce,
    input  logic   we,
    input  logic   busy_in_n,
    output logic   busy_n_d,
    output logic   arr_we_d
);

    localparam owner_e LOSE_TO = (SIDE == SIDE_L) ? OWN_RIGHT : OWN_LEFT;

    logic lost;

    always_comb begin
        lost     = (owner_d == LOSE_TO);
        busy_n_d = !(master_mode && lost);
        if (master_mode) begin
            arr_we_d = ce && we && !lost;
        end else begin
            arr_we_d = ce && we && busy_in_n;
        end
    end

endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W        = 14,
    parameter bit LEFT_WINS_TIE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_arr_we,
    output logic              r_arr_we
);

    typedef struct packed {
        owner_e            owner;
        logic              prev_l_ce;
        logic              prev_r_ce;
        logic [ADDR_W-1:0] prev_l_addr;
        logic [ADDR_W-1:0] prev_r_addr;
        logic [NUM_SIDES-1:0] busy_n;
        logic [NUM_SIDES-1:0] arr_we;
    } state_t;

    localparam state_t RESET_STATE = '{
        owner:       OWN_NONE,
        prev_l_ce:   1'b0,
        prev_r_ce:   1'b0,
        prev_l_addr: '0,
        prev_r_addr: '0,
        busy_n:      '1,
        arr_we:      '0
    };

    state_t st_d, st_q;

    logic   match, l_moved, r_moved;
    owner_e owner_d;

    logic [NUM_SIDES-1:0] side_ce, side_we, side_bin;
    logic [NUM_SIDES-1:0] side_busy_n_d, side_arr_we_d;

    dpa_match_detect #(.ADDR_W(ADDR_W)) u_match (
        .l_ce        (l_ce),
        .l_addr      (l_addr),
        .r_ce        (r_ce),
        .r_addr      (r_addr),
        .prev_l_ce   (st_q.prev_l_ce),
        .prev_l_addr (st_q.prev_l_addr),
        .prev_r_ce   (st_q.prev_r_ce),
        .prev_r_addr (st_q.prev_r_addr),
        .match       (match),
        .l_moved     (l_moved),
        .r_moved     (r_moved)
    );

    dpa_owner_next #(.LEFT_WINS_TIE(LEFT_WINS_TIE)) u_owner (
        .master_mode (master_mode),
        .match       (match),
        .l_moved     (l_moved),
        .r_moved     (r_moved),
        .owner_q     (st_q.owner),
        .owner_d     (owner_d)
    );

    assign side_ce  = {r_ce, l_ce};
    assign side_we  = {r_we, l_we};
    assign side_bin = {r_busy_in_n, l_busy_in_n};

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            dpa_write_gate #(.SIDE(s)) u_gate (
                .master_mode (master_mode),
                .owner_d     (owner_d),
                .ce          (side_ce[s]),
                .we          (side_we[s]),
                .busy_in_n   (side_bin[s]),
                .busy_n_d    (side_busy_n_d[s]),
                .arr_we_d    (side_arr_we_d[s])
            );
        end
    endgenerate

    always_comb begin
        st_d             = st_q;
        st_d.owner       = owner_d;
        st_d.prev_l_ce   = l_ce;
        st_d.prev_r_ce   = r_ce;
        st_d.prev_l_addr = l_addr;
        st_d.prev_r_addr = r_addr;
        st_d.busy_n      = side_busy_n_d;
        st_d.arr_we      = side_arr_we_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_busy_n = st_q.busy_n[SIDE_L];
    assign r_busy_n = st_q.busy_n[SIDE_R];
    assign l_arr_we = st_q.arr_we[SIDE_L];
    assign r_arr_we = st_q.arr_we[SIDE_R];

endmodule

// File: rtl/dpa_arbiter_checker.sv
module dpa_arbiter_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_ce,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_arr_we,
    input logic              r_arr_we
);

    logic in_match;
    assign in_match = l_ce && r_ce && (l_addr == r_addr);

    // R1 / R4: no match in the sampled inputs means no busy one clock later
    p_no_match_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_match |=> (l_busy_n && r_busy_n));

    // R5: mutual exclusion of busy
    p_never_both_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_n || r_busy_n));

    // R6: an existing loser stays the loser while the match persists
    p_owner_hold_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && in_match && !r_busy_n) |=> !r_busy_n);
    p_owner_hold_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && in_match && !l_busy_n) |=> !l_busy_n);

    // R7: a flagged loser never writes
    p_loser_no_write_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> !l_arr_we);
    p_loser_no_write_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> !r_arr_we);

    // R8: slave role keeps busy released and obeys the incoming busy
    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (l_busy_n && r_busy_n));
    p_slave_gate_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !l_busy_in_n) |=> !l_arr_we);
    p_slave_gate_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !r_busy_in_n) |=> !r_arr_we);

    // R7 / R8: no write strobe, no array write
    p_no_strobe_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(l_ce && l_we)) |=> !l_arr_we);

endmodule

bind dp_contention_arbiter dpa_arbiter_checker #(.ADDR_W(ADDR_W)) u_dpa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_ce        (l_ce),
    .l_we        (l_we),
    .l_addr      (l_addr),
    .r_ce        (r_ce),
    .r_we        (r_we),
    .r_addr      (r_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_arr_we    (l_arr_we),
    .r_arr_we    (r_arr_we)
);

// File: tb/dp_contention_arbiter_bench.sv
module dp_contention_arbiter_bench;

    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              master_mode = 1'b1;
    logic              l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic              l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic              l_busy_n, r_busy_n, l_arr_we, r_arr_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state: 0 none, 1 left owns, 2 right owns
    int                m_owner = 0;
    logic              m_pl_ce = 1'b0, m_pr_ce = 1'b0;
    logic [ADDR_W-1:0] m_pl_addr = '0, m_pr_addr = '0;
    logic e_lb, e_rb, e_lw, e_rw;

    always #2.5 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(ADDR_W)) u_dp_contention_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_arr_we(l_arr_we), .r_arr_we(r_arr_we)
    );

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // model of the requirements, evaluated on the vector just applied
    function automatic void model_step();
        logic mt, lmv, rmv;
        mt  = l_ce && r_ce && (l_addr == r_addr);
        lmv = !m_pl_ce || (l_addr != m_pl_addr);
        rmv = !m_pr_ce || (r_addr != m_pr_addr);
        if (!master_mode || !mt)      m_owner = 0;
        else if (m_owner != 0)        m_owner = m_owner;
        else if (lmv && !rmv)         m_owner = 2;
        else if (rmv && !lmv)         m_owner = 1;
        else                          m_owner = 1;
        e_lb = !(m_owner == 2);
        e_rb = !(m_owner == 1);
        if (master_mode) begin
            e_lw = l_ce && l_we && (m_owner != 2);
            e_rw = r_ce && r_we && (m_owner != 1);
        end else begin
            e_lw = l_ce && l_we && l_busy_in_n;
            e_rw = r_ce && r_we && r_busy_in_n;
        end
        m_pl_ce = l_ce; m_pr_ce = r_ce;
        m_pl_addr = l_addr; m_pr_addr = r_addr;
    endfunction

    task automatic step(input logic lc, input logic lw, input int la,
                        input logic rc, input logic rw, input int ra,
                        input string tb, input string tw);
        @(negedge clk);
        l_ce = lc; l_we = lw; l_addr = ADDR_W'(la);
        r_ce = rc; r_we = rw; r_addr = ADDR_W'(ra);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tb, "l_busy_n", l_busy_n, e_lb);
        check(tb, "r_busy_n", r_busy_n, e_rb);
        check(tw, "l_arr_we", l_arr_we, e_lw);
        check(tw, "r_arr_we", r_arr_we, e_rw);
        check("R5", "not both busy", l_busy_n | r_busy_n, 1'b1);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1d2c3b4a);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        l_ce = 1'b1; l_we = 1'b1; r_ce = 1'b1; r_we = 1'b1;
        @(negedge clk);
        check("R9", "l_busy_n in reset", l_busy_n, 1'b1);
        check("R9", "r_busy_n in reset", r_busy_n, 1'b1);
        check("R9", "l_arr_we in reset", l_arr_we, 1'b0);
        check("R9", "r_arr_we in reset", r_arr_we, 1'b0);
        l_ce = 1'b0; l_we = 1'b0; r_ce = 1'b0; r_we = 1'b0;
        rst_n = 1'b1;

        // R1: different addresses, both enabled, both writing
        step(1, 1, 5, 1, 1, 9, "R1", "R7");
        // R2: right moves onto left's word; R7 right write suppressed
        step(1, 1, 5, 1, 1, 5, "R2", "R7");
        check("R2", "right busy after move", r_busy_n, 1'b0);
        step(1, 0, 5, 1, 1, 5, "R2", "R7");
        // R6: both move together, owner kept
        step(1, 0, 7, 1, 1, 7, "R6", "R7");
        check("R6", "right still busy", r_busy_n, 1'b0);
        // R4: left chip enable drops -> release
        step(0, 0, 7, 1, 1, 7, "R4", "R7");
        check("R4", "release on ce drop", r_busy_n, 1'b1);
        // R3: left re-enables on matching word -> left busy
        step(1, 1, 7, 1, 0, 7, "R3", "R7");
        check("R3", "left busy after ce", l_busy_n, 1'b0);
        check("R7", "left loser write blocked", l_arr_we, 1'b0);
        // R4: right moves away -> release
        step(1, 1, 7, 1, 0, 8, "R4", "R7");
        check("R4", "release on mismatch", l_busy_n, 1'b1);
        check("R7", "left write restored", l_arr_we, 1'b1);
        // R5: simultaneous arrival from idle -> left wins
        step(0, 0, 0, 0, 0, 0, "R1", "R7");
        step(1, 1, 3, 1, 1, 3, "R5", "R7");
        check("R5", "tie right busy", r_busy_n, 1'b0);
        check("R5", "tie left free", l_busy_n, 1'b1);
        // R5: both move in the same clock to a new common word from mismatch
        step(1, 0, 4, 1, 0, 6, "R1", "R7");
        step(1, 0, 6, 1, 0, 4, "R1", "R7");
        step(1, 0, 2, 1, 0, 2, "R5", "R7");

        // random master traffic on a narrow address set
        for (int i = 0; i < 400; i++) begin
            step($urandom % 4 != 0, $urandom % 2, $urandom % 3,
                 $urandom % 4 != 0, $urandom % 2, $urandom % 3, "R2", "R7");
        end

        // slave role
        step(0, 0, 0, 0, 0, 0, "R1", "R7");
        @(negedge clk);
        master_mode = 1'b0;
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b1;
        step(1, 1, 5, 1, 1, 5, "R8", "R8");
        check("R8", "slave left write blocked", l_arr_we, 1'b0);
        check("R8", "slave right write allowed", r_arr_we, 1'b1);
        check("R8", "slave busy released", l_busy_n & r_busy_n, 1'b1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            l_busy_in_n = $urandom % 2;
            r_busy_in_n = $urandom % 2;
            step($urandom % 4 != 0, $urandom % 2, $urandom % 3,
                 $urandom % 4 != 0, $urandom % 2, $urandom % 3, "R8", "R8");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule